// File: doc/BRIEF.md
# Cache Line Lock-Down Controller

This block keeps one lock bit for each line of a small set-associative instruction cache and a small set-associative data cache, and chooses the replacement way for each fill so that a locked line is never evicted. A coprocessor-style command port drives it. Each command carries a 3-bit sub-opcode, a 4-bit register selector, a read/write flag and a 32-bit data word.

The two caches are locked in different ways. The data side is modal. A single lock-mode bit in a small register decides whether each data fill is tagged as locked when it completes. The instruction side is locked per address. A fetch-and-lock command names a virtual address. If the external tag lookup reports a hit, the present line is marked locked at once. On a miss, the block raises a line request and holds it until fill-done returns, and that fill is installed as a locked line. Each cache also has a bulk unlock command that clears all of its lock bits in one cycle.

Tag storage, refill and translation sit outside the block. The block sees only fill events, a combinational probe result and the set-index bits of each address.

Top module: `lockdown_ctrl`

## Requirements
- R1: After synchronous reset, lock mode is 0, every lock bit and every per-set round-robin pointer is 0, and all pulse and request outputs are 0.
- R2: A write with selector 4'b0010 and sub-opcode 3'b000 stores data bit 0 as the lock mode and ignores bits 31:1. A read with the same encoding raises `cmd_rvalid` on the next cycle, with the mode in `cmd_rdata[0]` and zeros in bits 31:1.
- R3: The set of a fill is address bits [OFF_W +: SET_W]. Each fill produces an allocate pulse one cycle later. The chosen way is the first unlocked way found scanning upward from the set's pointer, with wrap-around. The pointer then moves to the way after the chosen one.
- R4: A data fill installed while lock mode is 1 sets that way's lock bit, and `dc_alloc_lock` reports 1. A fill installed while the mode is 0 leaves the way unlocked.
- R5: When every way of the target set is locked, the fill allocates nothing. A one-cycle `*_alloc_none` pulse appears instead of `*_alloc_valid`, and the pointer is unchanged.
- R6: A write with selector 4'b0010 and sub-opcode 3'b001 clears every data-cache lock bit in one cycle. Its data word is ignored and the lock mode is unchanged.
- R7: A fetch-and-lock (write, selector 4'b0001, sub-opcode 3'b000) with `ic_probe_hit`=1 locks way `ic_probe_way` of the addressed set. No line request is raised.
- R8: A fetch-and-lock that misses raises `ic_lkreq_valid` and `lk_busy` on the next cycle, with `ic_lkreq_addr` equal to the data word. Both stay up until `ic_fill_done` is sampled. That fill is allocated in the requested set with its lock bit set.
- R9: A write with selector 4'b0001 and sub-opcode 3'b001 clears every instruction-cache lock bit in one cycle. Its data word is ignored.
- R10: A lock or unlock command aimed at a cache whose enable is 0 has no effect and gives a one-cycle `cmd_dis_err` pulse.
- R11: A command with any other selector or sub-opcode has no effect and pulses `cmd_illegal` for one cycle. The same applies to any command presented while `lk_busy` is 1.
- R12: A read with selector 4'b0001, or with selector 4'b0010 and sub-opcode 3'b001, has no effect and raises neither `cmd_rvalid` nor an error pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op2 | input | 3 | Command sub-opcode |
| cmd_crm | input | 4 | Command register selector |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | ADDR_W | Command data word or virtual address |
| ic_enable | input | 1 | Instruction cache enabled |
| dc_enable | input | 1 | Data cache enabled |
| ic_probe_hit | input | 1 | External tag lookup hit for cmd_wdata |
| ic_probe_way | input | WAY_W | Way that hit |
| ic_fill_done | input | 1 | Instruction-cache fill completes this cycle |
| ic_fill_addr | input | ADDR_W | Address of a normal instruction fill |
| dc_fill_valid | input | 1 | Data-cache fill completes this cycle |
| dc_fill_addr | input | ADDR_W | Address of the data fill |
| cmd_rvalid | output | 1 | Lock-mode read data valid |
| cmd_rdata | output | 32 | Read data |
| cmd_illegal | output | 1 | Unknown or busy-time command pulse |
| cmd_dis_err | output | 1 | Command aimed at a disabled cache |
| lk_busy | output | 1 | Fetch-and-lock miss in progress |
| ic_lkreq_valid | output | 1 | Line request for fetch-and-lock |
| ic_lkreq_addr | output | ADDR_W | Requested line address |
| ic_alloc_valid | output | 1 | Instruction fill allocated |
| ic_alloc_way | output | WAY_W | Allocated instruction way |
| ic_alloc_lock | output | 1 | Allocated instruction line is locked |
| ic_alloc_none | output | 1 | Instruction set fully locked, nothing allocated |
| dc_alloc_valid | output | 1 | Data fill allocated |
| dc_alloc_way | output | WAY_W | Allocated data way |
| dc_alloc_lock | output | 1 | Allocated data line is locked |
| dc_alloc_none | output | 1 | Data set fully locked, nothing allocated |

## Verification
The hardest state to reach from the ports is an outstanding fetch-and-lock miss. In that state the request is waiting, other commands arrive and are refused, and a fully locked set or a bulk unlock has to be seen through allocation choices alone. The stimulus first fills a set with mode on until allocation reports none. It then starts a missed fetch-and-lock and issues commands during the wait, and releases the wait with a fill-done. Finally it probes the sets with ordinary fills, so that the lock state shows up in the chosen ways. A random phase then mixes overlapping fills, commands, disables and fill-done events against the cycle model.

// File: rtl/lkc_pkg.sv
package lkc_pkg;

  localparam logic [3:0] CRM_ICACHE = 4'b0001;
  localparam logic [3:0] CRM_DCACHE = 4'b0010;
  localparam logic [2:0] OP2_MAIN   = 3'b000;
  localparam logic [2:0] OP2_UNLOCK = 3'b001;

  typedef enum logic [2:0] {
    CK_NONE,
    CK_MODE_WR,
    CK_MODE_RD,
    CK_IC_LOCK,
    CK_IC_UNLK,
    CK_DC_UNLK,
    CK_QUIET_RD,
    CK_ILLEGAL
  } cmd_kind_e;

  typedef enum logic {
    FL_IDLE,
    FL_WAIT
  } flk_state_e;

endpackage

// File: rtl/lkc_cmd_dec.sv
module lkc_cmd_dec
  import lkc_pkg::*;
(
  input  logic            valid,
  input  logic [2:0]      op2,
  input  logic [3:0]      crm,
  input  logic            write,
  output cmd_kind_e       kind
);

  always_comb begin
    kind = CK_NONE;
    if (valid) begin
      kind = CK_ILLEGAL;
      if (crm == CRM_DCACHE && op2 == OP2_MAIN)
        kind = write ? CK_MODE_WR : CK_MODE_RD;
      else if (crm == CRM_DCACHE && op2 == OP2_UNLOCK)
        kind = write ? CK_DC_UNLK : CK_QUIET_RD;
      else if (crm == CRM_ICACHE && op2 == OP2_MAIN)
        kind = write ? CK_IC_LOCK : CK_QUIET_RD;
      else if (crm == CRM_ICACHE && op2 == OP2_UNLOCK)
        kind = write ? CK_IC_UNLK : CK_QUIET_RD;
    end
  end

endmodule

// File: rtl/lkc_victim.sv
module lkc_victim #(
  parameter int WAYS  = 2,
  parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]  locked,
  input  logic [WAY_W-1:0] start,
  output logic             found,
  output logic [WAY_W-1:0] way
);

  always_comb begin
    int idx;
    found = 1'b0;
    way   = start;
    // descending scan so the smallest offset from start wins
    for (int i = WAYS - 1; i >= 0; i--) begin
      idx = (int'(start) + i) % WAYS;
      if (!locked[idx]) begin
        found = 1'b1;
        way   = WAY_W'(idx);
      end
    end
  end

endmodule

// File: rtl/lkc_bank.sv
module lkc_bank #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic             fill_valid,
  input  logic [SET_W-1:0] fill_set,
  input  logic             fill_lock,
  input  logic             mark_valid,
  input  logic [SET_W-1:0] mark_set,
  input  logic [WAY_W-1:0] mark_way,
  output logic             alloc_valid,
  output logic [WAY_W-1:0] alloc_way,
  output logic             alloc_lock,
  output logic             alloc_none
);

  logic [SETS-1:0][WAYS-1:0]  lock_q;
  logic [SETS-1:0][WAY_W-1:0] ptr_q;
  logic                       v_found;
  logic [WAY_W-1:0]           v_way;
  logic [WAY_W-1:0]           v_next;

  lkc_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) i_victim (
    .locked (lock_q[fill_set]),
    .start  (ptr_q[fill_set]),
    .found  (v_found),
    .way    (v_way)
  );

  assign v_next = WAY_W'((int'(v_way) + 1) % WAYS);

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q      <= '0;
      ptr_q       <= '0;
      alloc_valid <= 1'b0;
      alloc_way   <= '0;
      alloc_lock  <= 1'b0;
      alloc_none  <= 1'b0;
    end else begin
      alloc_valid <= 1'b0;
      alloc_none  <= 1'b0;
      if (clr_all)
        lock_q <= '0;
      if (fill_valid) begin
        if (v_found) begin
          lock_q[fill_set][v_way] <= fill_lock;
          ptr_q[fill_set]         <= v_next;
          alloc_valid             <= 1'b1;
          alloc_way               <= v_way;
          alloc_lock              <= fill_lock;
        end else begin
          alloc_none <= 1'b1;
        end
      end
      if (mark_valid)
        lock_q[mark_set][mark_way] <= 1'b1;
    end
  end

endmodule

// File: rtl/lockdown_ctrl.sv
module lockdown_ctrl
  import lkc_pkg::*;
#(
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int LINE_BYTES = 32,
  parameter int ADDR_W     = 32,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int SET_W     = $clog2(SETS),
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op2,
  input  logic [3:0]        cmd_crm,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_wdata,
  input  logic              ic_enable,
  input  logic              dc_enable,
  input  logic              ic_probe_hit,
  input  logic [WAY_W-1:0]  ic_probe_way,
  input  logic              ic_fill_done,
  input  logic [ADDR_W-1:0] ic_fill_addr,
  input  logic              dc_fill_valid,
  input  logic [ADDR_W-1:0] dc_fill_addr,
  output logic              cmd_rvalid,
  output logic [31:0]       cmd_rdata,
  output logic              cmd_illegal,
  output logic              cmd_dis_err,
  output logic              lk_busy,
  output logic              ic_lkreq_valid,
  output logic [ADDR_W-1:0] ic_lkreq_addr,
  output logic              ic_alloc_valid,
  output logic [WAY_W-1:0]  ic_alloc_way,
  output logic              ic_alloc_lock,
  output logic              ic_alloc_none,
  output logic              dc_alloc_valid,
  output logic [WAY_W-1:0]  dc_alloc_way,
  output logic              dc_alloc_lock,
  output logic              dc_alloc_none
);

  cmd_kind_e  kind;
  flk_state_e state_q;
  logic       mode_q;
  logic       busy;
  logic       cmd_ok;
  logic       ic_clr, dc_clr, ic_mark;
  logic [SET_W-1:0] ic_fset;
  logic       unused_bits;

  lkc_cmd_dec i_dec (
    .valid (cmd_valid),
    .op2   (cmd_op2),
    .crm   (cmd_crm),
    .write (cmd_write),
    .kind  (kind)
  );

  assign busy    = (state_q == FL_WAIT);
  assign lk_busy = busy;
  assign cmd_ok  = cmd_valid && !busy;
  assign ic_clr  = cmd_ok && kind == CK_IC_UNLK && ic_enable;
  assign dc_clr  = cmd_ok && kind == CK_DC_UNLK && dc_enable;
  assign ic_mark = cmd_ok && kind == CK_IC_LOCK && ic_enable && ic_probe_hit;
  assign ic_fset = busy ? ic_lkreq_addr[OFF_W +: SET_W] : ic_fill_addr[OFF_W +: SET_W];

  assign unused_bits = ^{ic_fill_addr, dc_fill_addr};

  lkc_bank #(.SETS(SETS), .WAYS(WAYS)) i_ibank (
    .clk         (clk),
    .rst         (rst),
    .clr_all     (ic_clr),
    .fill_valid  (ic_fill_done),
    .fill_set    (ic_fset),
    .fill_lock   (busy),
    .mark_valid  (ic_mark),
    .mark_set    (cmd_wdata[OFF_W +: SET_W]),
    .mark_way    (ic_probe_way),
    .alloc_valid (ic_alloc_valid),
    .alloc_way   (ic_alloc_way),
    .alloc_lock  (ic_alloc_lock),
    .alloc_none  (ic_alloc_none)
  );

  lkc_bank #(.SETS(SETS), .WAYS(WAYS)) i_dbank (
    .clk         (clk),
    .rst         (rst),
    .clr_all     (dc_clr),
    .fill_valid  (dc_fill_valid),
    .fill_set    (dc_fill_addr[OFF_W +: SET_W]),
    .fill_lock   (mode_q),
    .mark_valid  (1'b0),
    .mark_set    ('0),
    .mark_way    ('0),
    .alloc_valid (dc_alloc_valid),
    .alloc_way   (dc_alloc_way),
    .alloc_lock  (dc_alloc_lock),
    .alloc_none  (dc_alloc_none)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= FL_IDLE;
      mode_q         <= 1'b0;
      cmd_rvalid     <= 1'b0;
      cmd_rdata      <= '0;
      cmd_illegal    <= 1'b0;
      cmd_dis_err    <= 1'b0;
      ic_lkreq_valid <= 1'b0;
      ic_lkreq_addr  <= '0;
    end else begin
      cmd_rvalid  <= 1'b0;
      cmd_illegal <= 1'b0;
      cmd_dis_err <= 1'b0;
      if (cmd_valid && busy) begin
        cmd_illegal <= 1'b1;
      end else begin
        unique case (kind)
          CK_MODE_WR: mode_q <= cmd_wdata[0];
          CK_MODE_RD: begin
            cmd_rvalid <= 1'b1;
            cmd_rdata  <= {31'd0, mode_q};
          end
          CK_IC_LOCK: begin
            if (!ic_enable) begin
              cmd_dis_err <= 1'b1;
            end else if (!ic_probe_hit) begin
              state_q        <= FL_WAIT;
              ic_lkreq_valid <= 1'b1;
              ic_lkreq_addr  <= cmd_wdata;
            end
          end
          CK_IC_UNLK: if (!ic_enable) cmd_dis_err <= 1'b1;
          CK_DC_UNLK: if (!dc_enable) cmd_dis_err <= 1'b1;
          CK_ILLEGAL: cmd_illegal <= 1'b1;
          default: ;
        endcase
      end
      if (busy && ic_fill_done) begin
        state_q        <= FL_IDLE;
        ic_lkreq_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lkc_checker.sv
module lkc_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_write,
  input logic [3:0]        cmd_crm,
  input logic [2:0]        cmd_op2,
  input logic              ic_enable,
  input logic              dc_enable,
  input logic              ic_probe_hit,
  input logic              ic_fill_done,
  input logic              dc_fill_valid,
  input logic              cmd_rvalid,
  input logic              cmd_illegal,
  input logic              cmd_dis_err,
  input logic              ic_lkreq_valid,
  input logic [ADDR_W-1:0] ic_lkreq_addr,
  input logic              ic_alloc_valid,
  input logic              ic_alloc_none,
  input logic              dc_alloc_valid,
  input logic              dc_alloc_none
);

  a_r3_dc_alloc_after_fill: assert property (@(posedge clk) disable iff (rst)
    (dc_alloc_valid || dc_alloc_none) |-> $past(dc_fill_valid));

  a_r3_ic_alloc_after_fill: assert property (@(posedge clk) disable iff (rst)
    (ic_alloc_valid || ic_alloc_none) |-> $past(ic_fill_done));

  a_r5_dc_none_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(dc_alloc_valid && dc_alloc_none));

  a_r5_ic_none_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ic_alloc_valid && ic_alloc_none));

  a_r2_rvalid_after_read: assert property (@(posedge clk) disable iff (rst)
    cmd_rvalid |-> $past(cmd_valid && !cmd_write));

  a_r8_req_from_miss: assert property (@(posedge clk) disable iff (rst)
    $rose(ic_lkreq_valid) |-> $past(cmd_valid && cmd_write && cmd_crm == 4'b0001 &&
                                    cmd_op2 == 3'b000 && ic_enable && !ic_probe_hit));

  a_r8_req_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (ic_lkreq_valid && $past(ic_lkreq_valid)) |-> $stable(ic_lkreq_addr));

  a_r10_dis_needs_disable: assert property (@(posedge clk) disable iff (rst)
    cmd_dis_err |-> $past(cmd_valid && cmd_write && (!ic_enable || !dc_enable)));

  a_r11_single_error: assert property (@(posedge clk) disable iff (rst)
    !(cmd_illegal && cmd_dis_err));

endmodule

bind lockdown_ctrl lkc_checker #(.ADDR_W(ADDR_W)) i_lkc_checker (
  .clk            (clk),
  .rst            (rst),
  .cmd_valid      (cmd_valid),
  .cmd_write      (cmd_write),
  .cmd_crm        (cmd_crm),
  .cmd_op2        (cmd_op2),
  .ic_enable      (ic_enable),
  .dc_enable      (dc_enable),
  .ic_probe_hit   (ic_probe_hit),
  .ic_fill_done   (ic_fill_done),
  .dc_fill_valid  (dc_fill_valid),
  .cmd_rvalid     (cmd_rvalid),
  .cmd_illegal    (cmd_illegal),
  .cmd_dis_err    (cmd_dis_err),
  .ic_lkreq_valid (ic_lkreq_valid),
  .ic_lkreq_addr  (ic_lkreq_addr),
  .ic_alloc_valid (ic_alloc_valid),
  .ic_alloc_none  (ic_alloc_none),
  .dc_alloc_valid (dc_alloc_valid),
  .dc_alloc_none  (dc_alloc_none)
);

// File: tb/test_lockdown_ctrl.sv
module test_lockdown_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int S  = 4;
  localparam int W  = 2;
  localparam int OFF = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 0;
  logic [2:0]  cmd_op2 = 0;
  logic [3:0]  cmd_crm = 0;
  logic        cmd_write = 0;
  logic [31:0] cmd_wdata = 0;
  logic        ic_enable = 1, dc_enable = 1;
  logic        ic_probe_hit = 0;
  logic [0:0]  ic_probe_way = 0;
  logic        ic_fill_done = 0;
  logic [31:0] ic_fill_addr = 0;
  logic        dc_fill_valid = 0;
  logic [31:0] dc_fill_addr = 0;

  logic        cmd_rvalid, cmd_illegal, cmd_dis_err, lk_busy, ic_lkreq_valid;
  logic [31:0] cmd_rdata, ic_lkreq_addr;
  logic        ic_alloc_valid, ic_alloc_lock, ic_alloc_none;
  logic        dc_alloc_valid, dc_alloc_lock, dc_alloc_none;
  logic [0:0]  ic_alloc_way, dc_alloc_way;

  always #(CLK_PERIOD/2) clk = ~clk;

  lockdown_ctrl i_lockdown_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op2(cmd_op2), .cmd_crm(cmd_crm),
    .cmd_write(cmd_write), .cmd_wdata(cmd_wdata), .ic_enable(ic_enable), .dc_enable(dc_enable),
    .ic_probe_hit(ic_probe_hit), .ic_probe_way(ic_probe_way), .ic_fill_done(ic_fill_done),
    .ic_fill_addr(ic_fill_addr), .dc_fill_valid(dc_fill_valid), .dc_fill_addr(dc_fill_addr),
    .cmd_rvalid(cmd_rvalid), .cmd_rdata(cmd_rdata), .cmd_illegal(cmd_illegal),
    .cmd_dis_err(cmd_dis_err), .lk_busy(lk_busy), .ic_lkreq_valid(ic_lkreq_valid),
    .ic_lkreq_addr(ic_lkreq_addr), .ic_alloc_valid(ic_alloc_valid), .ic_alloc_way(ic_alloc_way),
    .ic_alloc_lock(ic_alloc_lock), .ic_alloc_none(ic_alloc_none),
    .dc_alloc_valid(dc_alloc_valid), .dc_alloc_way(dc_alloc_way),
    .dc_alloc_lock(dc_alloc_lock), .dc_alloc_none(dc_alloc_none)
  );

  // ---------------- reference model ----------------
  int lk [2][S][W];
  int pt [2][S];
  int m_mode, m_busy;
  logic [31:0] m_laddr;
  int e_av[2], e_way[2], e_lk[2], e_none[2];
  int e_rv, e_rd, e_ill, e_dis;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string phase = "R1";

  function automatic int set_of(logic [31:0] a);
    return int'(a[OFF +: 2]);
  endfunction

  function automatic void pick(int c, int s, output int found, output int w);
    found = 0; w = 0;
    for (int i = W - 1; i >= 0; i--) begin
      int x;
      x = (pt[c][s] + i) % W;
      if (lk[c][s][x] == 0) begin found = 1; w = x; end
    end
  endfunction

  function automatic void model_reset();
    foreach (lk[c, s, w]) lk[c][s][w] = 0;
    foreach (pt[c, s]) pt[c][s] = 0;
    m_mode = 0; m_busy = 0; m_laddr = 0;
    for (int c = 0; c < 2; c++) begin e_av[c] = 0; e_none[c] = 0; e_way[c] = 0; e_lk[c] = 0; end
    e_rv = 0; e_rd = 0; e_ill = 0; e_dis = 0;
  endfunction

  function automatic void model_step();
    int fv[2], fs[2], fl[2], ff[2], fw[2];
    int clr_i, clr_d, mark, nmode, nbusy;
    logic [31:0] nladdr;
    fv[0] = int'(ic_fill_done);  fs[0] = m_busy ? set_of(m_laddr) : set_of(ic_fill_addr); fl[0] = m_busy;
    fv[1] = int'(dc_fill_valid); fs[1] = set_of(dc_fill_addr); fl[1] = m_mode;
    for (int c = 0; c < 2; c++) begin
      e_av[c] = 0; e_none[c] = 0; ff[c] = 0; fw[c] = 0;
      if (fv[c] != 0) begin
        pick(c, fs[c], ff[c], fw[c]);
        if (ff[c] != 0) begin e_av[c] = 1; e_way[c] = fw[c]; e_lk[c] = fl[c]; end
        else e_none[c] = 1;
      end
    end
    e_rv = 0; e_ill = 0; e_dis = 0;
    clr_i = 0; clr_d = 0; mark = 0; nmode = m_mode; nbusy = m_busy; nladdr = m_laddr;
    if (cmd_valid && m_busy != 0) e_ill = 1;
    else if (cmd_valid) begin
      if (cmd_crm == 4'd2 && cmd_op2 == 3'd0) begin
        if (cmd_write) nmode = int'(cmd_wdata[0]);
        else begin e_rv = 1; e_rd = m_mode; end
      end else if (cmd_crm == 4'd2 && cmd_op2 == 3'd1) begin
        if (cmd_write) begin if (dc_enable) clr_d = 1; else e_dis = 1; end
      end else if (cmd_crm == 4'd1 && cmd_op2 == 3'd0) begin
        if (cmd_write) begin
          if (!ic_enable) e_dis = 1;
          else if (ic_probe_hit) mark = 1;
          else begin nbusy = 1; nladdr = cmd_wdata; end
        end
      end else if (cmd_crm == 4'd1 && cmd_op2 == 3'd1) begin
        if (cmd_write) begin if (ic_enable) clr_i = 1; else e_dis = 1; end
      end else e_ill = 1;
    end
    if (m_busy != 0 && ic_fill_done) nbusy = 0;
    if (clr_i != 0) for (int s = 0; s < S; s++) for (int w = 0; w < W; w++) lk[0][s][w] = 0;
    if (clr_d != 0) for (int s = 0; s < S; s++) for (int w = 0; w < W; w++) lk[1][s][w] = 0;
    for (int c = 0; c < 2; c++)
      if (fv[c] != 0 && ff[c] != 0) begin
        lk[c][fs[c]][fw[c]] = fl[c];
        pt[c][fs[c]] = (fw[c] + 1) % W;
      end
    if (mark != 0) lk[0][set_of(cmd_wdata)][int'(ic_probe_way)] = 1;
    m_mode = nmode; m_busy = nbusy; m_laddr = nladdr;
  endfunction

  task automatic chk(string f, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, f, act, exp);
    end
  endtask

  task automatic compare();
    chk("ic_alloc_valid", 32'(ic_alloc_valid), 32'(e_av[0]));
    chk("ic_alloc_none",  32'(ic_alloc_none),  32'(e_none[0]));
    if (e_av[0] != 0) begin
      chk("ic_alloc_way",  32'(ic_alloc_way),  32'(e_way[0]));
      chk("ic_alloc_lock", 32'(ic_alloc_lock), 32'(e_lk[0]));
    end
    chk("dc_alloc_valid", 32'(dc_alloc_valid), 32'(e_av[1]));
    chk("dc_alloc_none",  32'(dc_alloc_none),  32'(e_none[1]));
    if (e_av[1] != 0) begin
      chk("dc_alloc_way",  32'(dc_alloc_way),  32'(e_way[1]));
      chk("dc_alloc_lock", 32'(dc_alloc_lock), 32'(e_lk[1]));
    end
    chk("cmd_rvalid", 32'(cmd_rvalid), 32'(e_rv));
    if (e_rv != 0) chk("cmd_rdata", cmd_rdata, 32'(e_rd));
    chk("cmd_illegal", 32'(cmd_illegal), 32'(e_ill));
    chk("cmd_dis_err", 32'(cmd_dis_err), 32'(e_dis));
    chk("lk_busy", 32'(lk_busy), 32'(m_busy));
    chk("ic_lkreq_valid", 32'(ic_lkreq_valid), 32'(m_busy));
    if (m_busy != 0) chk("ic_lkreq_addr", ic_lkreq_addr, m_laddr);
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst) model_reset(); else model_step();
    @(negedge clk);
    compare();
    cmd_valid = 0; ic_fill_done = 0; dc_fill_valid = 0; ic_probe_hit = 0;
  endtask

  function automatic logic [31:0] ad(int s, int tag);
    return (32'(tag) << 7) | (32'(s) << OFF);
  endfunction

  task automatic cmd(logic [3:0] crm, logic [2:0] op2, logic wr, logic [31:0] d);
    cmd_valid = 1; cmd_crm = crm; cmd_op2 = op2; cmd_write = wr; cmd_wdata = d;
    tick();
  endtask

  task automatic dfill(int s);
    dc_fill_valid = 1; dc_fill_addr = ad(s, 3); tick();
  endtask

  task automatic ifill(int s);
    ic_fill_done = 1; ic_fill_addr = ad(s, 5); tick();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    // R1: reset state, then fresh pointers start at way 0
    phase = "R1";
    idle(3);
    rst = 0;
    idle(2);
    dfill(0); dfill(0); ifill(0);

    // R2: lock-mode register write and read, upper bits ignored
    phase = "R2";
    cmd(4'd2, 3'd0, 1, 32'h0000_0001);
    cmd(4'd2, 3'd0, 0, 32'h0);
    cmd(4'd2, 3'd0, 1, 32'hFFFF_FFFE);
    cmd(4'd2, 3'd0, 0, 32'h0);

    // R3: round-robin across several sets
    phase = "R3";
    for (int i = 0; i < 6; i++) dfill(i % S);
    dc_fill_valid = 1; dc_fill_addr = ad(2, 1); ic_fill_done = 1; ic_fill_addr = ad(2, 9); tick();

    // R4: modal locking on the data side
    phase = "R4";
    cmd(4'd2, 3'd0, 1, 32'h1);
    dfill(1); dfill(1);
    dfill(2);
    cmd(4'd2, 3'd0, 1, 32'h0);
    for (int i = 0; i < 4; i++) dfill(2);

    // R5: fully locked set allocates nothing
    phase = "R5";
    dfill(1); dfill(1); dfill(3);

    // R6: data unlock clears all locks, keeps mode
    phase = "R6";
    cmd(4'd2, 3'd0, 1, 32'h1);
    cmd(4'd2, 3'd1, 1, 32'hDEAD_BEEF);
    cmd(4'd2, 3'd0, 0, 32'h0);
    cmd(4'd2, 3'd0, 1, 32'h0);
    dfill(1); dfill(1); dfill(2); dfill(2);

    // R7: fetch-and-lock hit marks a present line
    phase = "R7";
    ic_probe_hit = 1; ic_probe_way = 1'b1;
    cmd(4'd1, 3'd0, 1, ad(3, 7));
    for (int i = 0; i < 3; i++) ifill(3);

    // R8: fetch-and-lock miss with a wait; R11: commands during wait refused
    phase = "R8";
    cmd(4'd1, 3'd0, 1, ad(2, 11) | 32'h4);
    idle(2);
    phase = "R11";
    cmd(4'd2, 3'd0, 1, 32'h1);
    cmd(4'd1, 3'd1, 1, 32'h0);
    phase = "R8";
    ifill(0);
    for (int i = 0; i < 3; i++) ifill(2);

    // R9: instruction unlock frees set 3 and set 2
    phase = "R9";
    cmd(4'd1, 3'd1, 1, 32'h1234_5678);
    for (int i = 0; i < 3; i++) ifill(3);
    ifill(2); ifill(2);

    // R10: commands to disabled caches are ignored
    phase = "R10";
    ic_probe_hit = 1; ic_probe_way = 1'b0;
    cmd(4'd1, 3'd0, 1, ad(0, 1));
    ic_enable = 0;
    cmd(4'd1, 3'd0, 1, ad(1, 1));
    cmd(4'd1, 3'd1, 1, 32'h0);
    ic_enable = 1;
    for (int i = 0; i < 3; i++) ifill(0);
    cmd(4'd2, 3'd0, 1, 32'h1);
    dfill(0); dfill(0);
    cmd(4'd2, 3'd0, 1, 32'h0);
    dc_enable = 0;
    cmd(4'd2, 3'd1, 1, 32'h0);
    dc_enable = 1;
    dfill(0);

    // R11: unknown encodings
    phase = "R11";
    cmd(4'd3, 3'd0, 1, 32'h1);
    cmd(4'd2, 3'd2, 1, 32'h1);
    cmd(4'd0, 3'd0, 0, 32'h0);
    cmd(4'd2, 3'd0, 0, 32'h0);

    // R12: reads of write-only functions are quiet
    phase = "R12";
    cmd(4'd1, 3'd0, 0, ad(1, 2));
    cmd(4'd1, 3'd1, 0, 32'h0);
    cmd(4'd2, 3'd1, 0, 32'h0);
    dfill(0);

    // R4: random mix of overlapping traffic against the model
    phase = "R4";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cmd_valid     = (r[3:0] < 4'd5);
      cmd_crm       = 4'(r[5:4]);
      cmd_op2       = 3'(r[7:6] % 3);
      cmd_write     = r[8] | r[9];
      cmd_wdata     = $urandom;
      ic_probe_hit  = r[10];
      ic_probe_way  = r[11];
      ic_enable     = (r[14:12] != 0);
      dc_enable     = (r[17:15] != 0);
      ic_fill_done  = r[18] & r[19];
      ic_fill_addr  = $urandom;
      dc_fill_valid = r[20];
      dc_fill_addr  = $urandom;
      tick();
    end
    ic_enable = 1; dc_enable = 1;
    ic_fill_done = 1; tick();
    idle(2);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule